// File: doc/BRIEF.md
# Triggered 16-Byte DMA Burst Requester

This block is the device-side request logic of a storage adapter that sits on an 8-bit bus next to a demand-mode DMA controller. Software starts every burst by writing to the adapter's control register. The value written does not matter. The block then raises its DMA request and keeps it high until 16 acknowledged byte transfers have completed. The DMA controller's terminal-count pulse also ends the burst early, which is how a short final block is finished. When the request drops, the bus goes back to the CPU, so refresh cycles and other channels get service between bursts.

During a burst, each acknowledged bus cycle moves one byte between the bus and a simple byte FIFO interface. The direction input selects which way the bytes move:

- **Device-to-memory:** the block drives the FIFO head onto the bus during acknowledged reads.
- **Memory-to-device:** the block hands bus data to the FIFO during acknowledged writes.

All bus inputs are taken as already synchronous to `clk`. Each cycle that has an acknowledge together with the correct strobe counts as one transfer.

Top module: `drq_burst_requester`

## Requirements
- R1: While reset is asserted and after it is released, `drq` is low and `rdFifoPop`, `wrFifoPush` and `busDataOe` are all low until a burst begins.
- R2: A one-cycle `ctrlWr` pulse while `drq` is low sets `drq` high from the next clock edge, and the transfer count of the new burst starts at zero.
- R3: `drq` falls at the clock edge that ends the 16th counted transfer of a burst.
- R4: If `tc` is high at a clock edge while `drq` is high, `drq` is low after that edge, however many transfers have been counted. If `tc` is high while `drq` is low, it has no effect.
- R5: With `dirToMem`=1, every cycle with `drq`, `dack` and `ior` all high is a counted transfer. In that cycle `busDataOe`=1, `busDataOut` equals `rdFifoData`, and `rdFifoPop`=1.
- R6: With `dirToMem`=0, every cycle with `drq`, `dack` and `iow` all high is a counted transfer. In that cycle `wrFifoPush`=1 and `wrFifoData` equals `busDataIn`.
- R7: A `ctrlWr` pulse while `drq` is high is ignored. The burst still ends after 16 transfers counted from its own start.
- R8: While `drq` is low, `dack` cycles with either strobe cause no pop, no push and no bus drive.
- R9: During a burst, a strobe that does not match the direction (`iow` when `dirToMem`=1, `ior` when `dirToMem`=0) moves no data and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrlWr | input | 1 | One-cycle strobe: CPU write to the control register (data ignored) |
| dirToMem | input | 1 | 1: device-to-memory, 0: memory-to-device |
| dack | input | 1 | DMA acknowledge for this channel |
| ior | input | 1 | I/O read strobe |
| iow | input | 1 | I/O write strobe |
| tc | input | 1 | Terminal count from the DMA controller |
| busDataIn | input | 8 | Bus data seen during memory-to-device cycles |
| busDataOut | output | 8 | Bus data driven during device-to-memory cycles |
| busDataOe | output | 1 | Output enable for `busDataOut` |
| drq | output | 1 | DMA request |
| rdFifoData | input | 8 | Head byte of the outbound FIFO |
| rdFifoPop | output | 1 | Pop the outbound FIFO |
| wrFifoData | output | 8 | Byte pushed into the inbound FIFO |
| wrFifoPush | output | 1 | Push into the inbound FIFO |

## Verification
The data-path results (`busDataOe`, `busDataOut`, `rdFifoPop`, `wrFifoPush`, `wrFifoData`) are combinational. The bench drives each bus cycle just after a falling edge and checks these outputs 1 ns later, in the same cycle. The `drq` results (start, count end, terminal count) are registered and take effect one edge after the causing cycle. The bench checks `drq` at the following falling edge, against a reference model that it updates only after the rising edge.

// File: rtl/drq_burst_pkg.sv
package drq_burst_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clearCnt;  // start of a new burst
    logic incCnt;    // one counted transfer
  } ctrlStrobes_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } burstState_t;

endpackage

// File: rtl/drq_burst_ctrl.sv
module drq_burst_ctrl
  import drq_burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrlWr,
  input  logic         tc,
  input  logic         xferHit,
  input  logic         lastBeat,
  output logic         busy,
  output ctrlStrobes_t strobes
);

  burstState_t stateQ, stateD;

  always_comb begin
    stateD          = stateQ;
    strobes         = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (ctrlWr) begin
          stateD           = ST_BURST;
          strobes.clearCnt = 1'b1;
        end
      end
      ST_BURST: begin
        // Trigger writes are ignored here.
        strobes.incCnt = xferHit;
        if (tc || (xferHit && lastBeat)) begin
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  assign busy = (stateQ == ST_BURST);

endmodule

// File: rtl/drq_burst_datapath.sv
module drq_burst_datapath
  import drq_burst_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 16,
  localparam int CNT_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic              busy,
  input  logic              dirToMem,
  input  logic              dack,
  input  logic              ior,
  input  logic              iow,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic [DATA_W-1:0] rdFifoData,
  output logic              xferHit,
  output logic              lastBeat,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              rdFifoPop,
  output logic [DATA_W-1:0] wrFifoData,
  output logic              wrFifoPush
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BURST_LEN - 1);

  logic [CNT_W-1:0] beatCnt;
  logic             rdCycle, wrCycle;

  // Only the strobe that matches the direction qualifies a transfer.
  assign rdCycle = dack && ior &&  dirToMem;
  assign wrCycle = dack && iow && !dirToMem;
  assign xferHit = rdCycle || wrCycle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beatCnt <= '0;
    end else if (strobes.clearCnt) begin
      beatCnt <= '0;
    end else if (strobes.incCnt) begin
      beatCnt <= (beatCnt == LAST_IDX) ? '0 : beatCnt + 1'b1;
    end
  end

  assign lastBeat = (beatCnt == LAST_IDX);

  // Bus side, device-to-memory
  assign busDataOe  = busy && rdCycle;
  assign rdFifoPop  = busy && rdCycle;
  assign busDataOut = busDataOe ? rdFifoData : '0;

  // FIFO side, memory-to-device
  assign wrFifoPush = busy && wrCycle;
  assign wrFifoData = busDataIn;

endmodule

// File: rtl/drq_burst_requester.sv
module drq_burst_requester
  import drq_burst_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrlWr,
  input  logic              dirToMem,
  input  logic              dack,
  input  logic              ior,
  input  logic              iow,
  input  logic              tc,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              drq,
  input  logic [DATA_W-1:0] rdFifoData,
  output logic              rdFifoPop,
  output logic [DATA_W-1:0] wrFifoData,
  output logic              wrFifoPush
);

  ctrlStrobes_t strobes;
  logic         busy, xferHit, lastBeat;

  drq_burst_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrlWr   (ctrlWr),
    .tc       (tc),
    .xferHit  (xferHit),
    .lastBeat (lastBeat),
    .busy     (busy),
    .strobes  (strobes)
  );

  drq_burst_datapath #(
    .DATA_W    (DATA_W),
    .BURST_LEN (BURST_LEN)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .busy       (busy),
    .dirToMem   (dirToMem),
    .dack       (dack),
    .ior        (ior),
    .iow        (iow),
    .busDataIn  (busDataIn),
    .rdFifoData (rdFifoData),
    .xferHit    (xferHit),
    .lastBeat   (lastBeat),
    .busDataOut (busDataOut),
    .busDataOe  (busDataOe),
    .rdFifoPop  (rdFifoPop),
    .wrFifoData (wrFifoData),
    .wrFifoPush (wrFifoPush)
  );

  assign drq = busy;

endmodule

// File: rtl/drq_burst_checker.sv
module drq_burst_checker #(
  parameter int BURST_LEN = 16
) (
  input logic clk,
  input logic rst_n,
  input logic ctrlWr,
  input logic dirToMem,
  input logic dack,
  input logic ior,
  input logic iow,
  input logic tc,
  input logic drq,
  input logic busDataOe,
  input logic rdFifoPop,
  input logic wrFifoPush
);

  localparam int BW = $clog2(BURST_LEN + 1) + 1;

  logic [BW-1:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                beats <= '0;
    else if (ctrlWr && !drq)   beats <= '0;
    else if (rdFifoPop || wrFifoPush) beats <= beats + 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_quiet: assert (!drq && !rdFifoPop && !wrFifoPush);
  end

  a_r2_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drq) |-> $past(ctrlWr));

  a_r3_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (beats >= BW'(BURST_LEN)) |-> !drq);

  a_r4_tc_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && tc) |=> !drq);

  a_r5_drive_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    busDataOe |-> (drq && dack && ior && dirToMem));

  a_r6_push_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    wrFifoPush |-> (drq && dack && iow && !dirToMem));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !drq |-> (!rdFifoPop && !wrFifoPush && !busDataOe));

  a_r9_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdFifoPop && wrFifoPush));

endmodule

bind drq_burst_requester drq_burst_checker #(.BURST_LEN(BURST_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrlWr     (ctrlWr),
  .dirToMem   (dirToMem),
  .dack       (dack),
  .ior        (ior),
  .iow        (iow),
  .tc         (tc),
  .drq        (drq),
  .busDataOe  (busDataOe),
  .rdFifoPop  (rdFifoPop),
  .wrFifoPush (wrFifoPush)
);

// File: tb/sim_drq_burst_requester.sv
`timescale 1ns/1ps
module sim_drq_burst_requester;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ctrlWr = 0, dirToMem = 0, dack = 0, ior = 0, iow = 0, tc = 0;
  logic [7:0] busDataIn = 0, rdFifoData = 0;
  logic [7:0] busDataOut, wrFifoData;
  logic       busDataOe, drq, rdFifoPop, wrFifoPush;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model
  bit    mBusy = 0;
  int    mCnt  = 0;
  string lastTag = "R1";

  always #2.5 clk = ~clk;

  drq_burst_requester u0 (
    .clk(clk), .rst_n(rst_n), .ctrlWr(ctrlWr), .dirToMem(dirToMem),
    .dack(dack), .ior(ior), .iow(iow), .tc(tc), .busDataIn(busDataIn),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .drq(drq),
    .rdFifoData(rdFifoData), .rdFifoPop(rdFifoPop),
    .wrFifoData(wrFifoData), .wrFifoPush(wrFifoPush)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit expRead(bit busy, bit d, bit r, bit dir);
    return busy && d && r && dir;
  endfunction

  function automatic bit expWrite(bit busy, bit d, bit w, bit dir);
    return busy && d && w && !dir;
  endfunction

  // One bus cycle: drive at falling edge, check combinational outputs,
  // update the model after the rising edge.
  task automatic step(bit cw, bit d, bit r, bit w, bit t, string tag);
    bit rd, wr;
    check(lastTag, drq, mBusy);
    ctrlWr = cw; dack = d; ior = r; iow = w; tc = t;
    busDataIn = 8'($urandom); rdFifoData = 8'($urandom);
    #1;
    rd = expRead(mBusy, d, r, dirToMem);
    wr = expWrite(mBusy, d, w, dirToMem);
    check(mBusy ? tag : "R8", rdFifoPop, rd);
    check(mBusy ? tag : "R8", busDataOe, rd);
    check(mBusy ? tag : "R8", wrFifoPush, wr);
    if (rd) check("R5", busDataOut, rdFifoData);
    if (wr) check("R6", wrFifoData, busDataIn);
    @(posedge clk);
    if (!mBusy) begin
      if (cw) begin mBusy = 1; mCnt = 0; lastTag = "R2"; end
    end else begin
      if (cw) lastTag = "R7";
      if (rd || wr) mCnt++;
      if (t) begin mBusy = 0; lastTag = "R4"; end
      else if (mCnt == 16) begin mBusy = 0; lastTag = "R3"; end
    end
    @(negedge clk);
    ctrlWr = 0; dack = 0; ior = 0; iow = 0; tc = 0;
  endtask

  task automatic beat(bit t);
    if (dirToMem) step(0, 1, 1, 0, t, "R5");
    else          step(0, 1, 0, 1, t, "R6");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1", drq, 0);
    check("R1", rdFifoPop | wrFifoPush | busDataOe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", drq, 0);

    // R8: acknowledged cycles while idle, tc while idle
    dirToMem = 1; step(0, 1, 1, 0, 0, "R8");
    dirToMem = 0; step(0, 1, 0, 1, 1, "R4");
    step(0, 0, 0, 0, 0, "R4");

    // R3 full burst each direction
    for (int dir = 0; dir < 2; dir++) begin
      dirToMem = dir[0];
      step(1, 0, 0, 0, 0, "R2");
      for (int i = 0; i < 16; i++) beat(0);
      step(0, 0, 0, 0, 0, "R3");
    end

    // R4 tc on first beat; R4 tc without transfer
    dirToMem = 1; step(1, 0, 0, 0, 0, "R2"); beat(1); step(0, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R2"); beat(0); step(0, 0, 0, 0, 1, "R4"); step(0,0,0,0,0,"R4");

    // R7 trigger mid-burst; R9 wrong strobes
    dirToMem = 0; step(1, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 8; i++) beat(0);
    step(1, 0, 0, 0, 0, "R7");
    step(0, 1, 1, 0, 0, "R9");
    for (int i = 0; i < 7; i++) beat(0);
    step(1, 1, 0, 1, 0, "R7");  // 16th beat with trigger: ignored
    step(0, 0, 0, 0, 0, "R3");

    // random bursts
    for (int b = 0; b < 60; b++) begin
      dirToMem = 1'($urandom);
      step(1, 0, 0, 0, 0, "R2");
      for (int k = 0; k < 80 && mBusy; k++) begin
        int p;
        bit t;
        p = int'($urandom % 100);
        t = ($urandom % 40) == 0;
        if (p < 70)      beat(t);
        else if (p < 80) step(0, 1, !dirToMem, dirToMem, t, "R9");
        else if (p < 90) step(0, 0, 0, 0, t, "R4");
        else             step(1, 0, 0, 0, t, "R7");
      end
      step(0, 1, dirToMem, !dirToMem, 0, "R8");
    end
    finish_run();
  end

endmodule